// File: doc/BRIEF.md
# Single-Entry Store Buffer with Load Forwarding

This block is the store buffer of one processor in a shared-memory machine with a single accumulator per core. It holds at most one pending store: an occupancy flag, a target address and a data word. A core store goes into the buffer, not to memory. A later load to the same address gets the buffered word. A load to any other address gets the word that shared memory returns, in the same cycle.

The buffer also decides which instruction classes the core may issue. Loads, register-modifying operations and control-flow operations may always issue. Stores, atomic operations, barriers and halt may issue only while the buffer is empty. Halt counts as a barrier, so a core cannot stop with a store still pending. An external scheduler drains the buffer by raising a flush request. In one cycle the processor either executes an instruction or flushes, never both. If a store and a flush are requested together, the block raises an error flag and drops both requests.

Top module: `sbe_top`

## Requirements
- R1: A synchronous active-high reset empties the buffer. While reset is held and in the first cycle after it, `flush_ok` and `mem_wr_en` are 0.
- R2: A store request (`st_req`=1, `fl_req`=0) made while the buffer is empty is accepted at the next clock edge. From the next cycle on, `flush_ok`=1 and the buffer holds `st_addr` and `acc_in`.
- R3: When the buffer is full and `ld_addr` equals the buffered address, `ld_data` equals the buffered word and `ld_fwd`=1 in the same cycle.
- R4: When the buffer is empty or `ld_addr` differs from the buffered address, `ld_data` equals `mem_rd_data` combinationally and `ld_fwd`=0.
- R5: `op_class` codes 3 (store), 4 (atomic), 5 (barrier), 6 (halt) and 7 (reserved) give `issue_ok`=0 while the buffer is full and `issue_ok`=1 while it is empty.
- R6: `op_class` codes 0 (load), 1 (modify) and 2 (control) give `issue_ok`=1 whatever the buffer state.
- R7: A flush request (`fl_req`=1, `st_req`=0) while the buffer is full empties it at the next edge. In the cycle after that edge, `mem_wr_en`=1 and `mem_wr_addr`/`mem_wr_data` carry the buffered address and word.
- R8: A flush request while the buffer is empty has no effect: `mem_wr_en` stays 0 and `flush_ok` stays 0.
- R9: A store request while the buffer is full is ignored. The buffered address and word stay unchanged, as seen through forwarding and through the next flush.
- R10: `st_req` and `fl_req` high together make `proto_err`=1 in that cycle. Neither request takes effect: occupancy, contents and `mem_wr_en` behave as if both were low.
- R11: `mem_wr_en` is high for exactly one cycle per accepted flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 3 | Class of the instruction the core wants to issue |
| issue_ok | output | 1 | The instruction class in `op_class` may issue now |
| st_req | input | 1 | Core store request |
| st_addr | input | AW | Store target address |
| acc_in | input | DW | Accumulator value to store |
| ld_addr | input | AW | Load address (also driven to shared memory) |
| mem_rd_data | input | DW | Word that shared memory returns for `ld_addr` |
| ld_data | output | DW | Load result, forwarded or from memory |
| ld_fwd | output | 1 | The load result came from the buffer |
| fl_req | input | 1 | Scheduler flush request |
| flush_ok | output | 1 | The buffer is full, so a flush may be requested |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| proto_err | output | 1 | A store and a flush were requested in the same cycle |

## Verification
The hardest case to reach is a store request that lands in the cycle right after a flush. The memory strobe is still high for the old entry while the new entry is being captured, so stale and fresh contents sit side by side. A bench that only alternates store and flush cleanly never exercises this. The stimulus therefore includes a directed back-to-back store, flush, store sequence. It also runs a long pseudo-random phase that draws from only four addresses and raises store and flush often, so that forwarding hits, ignored stores, simultaneous requests and flushes on an empty buffer all occur many times. A behavioural model checks every output on every cycle.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic [2:0] {
    OPC_LOAD    = 3'd0,
    OPC_MODIFY  = 3'd1,
    OPC_CONTROL = 3'd2,
    OPC_STORE   = 3'd3,
    OPC_ATOMIC  = 3'd4,
    OPC_BARRIER = 3'd5,
    OPC_HALT    = 3'd6,
    OPC_RSVD    = 3'd7
  } op_class_e;

  // Classes that need an empty buffer before they may issue.
  function automatic logic needs_empty(input logic [2:0] cls);
    return (cls >= 3'(OPC_STORE));
  endfunction

  // Forwarding hit test.
  function automatic logic fwd_hit(input logic full, input logic [63:0] a, input logic [63:0] b);
    return full && (a == b);
  endfunction

endpackage

// File: rtl/sbe_slot.sv
module sbe_slot #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clear,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          full,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (clear) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
    end
  end

  // Address and data keep their values after a flush; they only matter while full.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      data <= '0;
    end else if (load) begin
      addr <= in_addr;
      data <= in_data;
    end
  end
endmodule

// File: rtl/sbe_gate.sv
module sbe_gate
  import sbe_pkg::*;
(
  input  logic       full,
  input  logic [2:0] op_class,
  input  logic       st_req,
  input  logic       fl_req,
  output logic       issue_ok,
  output logic       st_accept,
  output logic       fl_accept,
  output logic       proto_err
);
  always_comb begin
    proto_err = st_req && fl_req;
    issue_ok  = !needs_empty(op_class) || !full;
    st_accept = st_req && !fl_req && !full;
    fl_accept = fl_req && !st_req && full;
  end
endmodule

// File: rtl/sbe_fwd.sv
module sbe_fwd
  import sbe_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          full,
  input  logic [AW-1:0] ent_addr,
  input  logic [DW-1:0] ent_data,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] ld_data,
  output logic          hit
);
  localparam int PADW = 64 - AW;
  always_comb begin
    hit     = fwd_hit(full, {{PADW{1'b0}}, ent_addr}, {{PADW{1'b0}}, ld_addr});
    ld_data = hit ? ent_data : mem_rd_data;
  end
endmodule

// File: rtl/sbe_top.sv
module sbe_top #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_class,
  output logic          issue_ok,
  input  logic          st_req,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] acc_in,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] ld_data,
  output logic          ld_fwd,
  input  logic          fl_req,
  output logic          flush_ok,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          proto_err
);
  // Named internal events.
  logic          full_q;
  logic [AW-1:0] ent_addr;
  logic [DW-1:0] ent_data;
  logic          st_accept;
  logic          fl_accept;
  logic          wr_pulse_q;

  sbe_gate u_gate (
    .full      (full_q),
    .op_class  (op_class),
    .st_req    (st_req),
    .fl_req    (fl_req),
    .issue_ok  (issue_ok),
    .st_accept (st_accept),
    .fl_accept (fl_accept),
    .proto_err (proto_err)
  );

  sbe_slot #(.AW(AW), .DW(DW)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .load    (st_accept),
    .clear   (fl_accept),
    .in_addr (st_addr),
    .in_data (acc_in),
    .full    (full_q),
    .addr    (ent_addr),
    .data    (ent_data)
  );

  sbe_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .full        (full_q),
    .ent_addr    (ent_addr),
    .ent_data    (ent_data),
    .ld_addr     (ld_addr),
    .mem_rd_data (mem_rd_data),
    .ld_data     (ld_data),
    .hit         (ld_fwd)
  );

  // Strobe rises on the same edge that clears the full flag.
  always_ff @(posedge clk) begin
    if (rst) wr_pulse_q <= 1'b0;
    else     wr_pulse_q <= fl_accept;
  end

  // The entry registers still hold the flushed pair during the strobe cycle.
  assign mem_wr_en   = wr_pulse_q;
  assign mem_wr_addr = ent_addr;
  assign mem_wr_data = ent_data;
  assign flush_ok    = full_q;
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op_class,
  input logic          issue_ok,
  input logic          st_req,
  input logic          fl_req,
  input logic [AW-1:0] ld_addr,
  input logic [DW-1:0] mem_rd_data,
  input logic [DW-1:0] ld_data,
  input logic          ld_fwd,
  input logic          mem_wr_en,
  input logic          proto_err,
  input logic          full_q,
  input logic [AW-1:0] ent_addr,
  input logic [DW-1:0] ent_data
);
  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> (!full_q && !mem_wr_en));

  assert_store_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (st_req && !fl_req && !full_q) |=> full_q);

  assert_fwd_hit_R3: assert property (@(posedge clk) disable iff (rst)
    ld_fwd |-> (full_q && ld_addr == ent_addr && ld_data == ent_data));

  assert_miss_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (!full_q || ld_addr != ent_addr) |-> (!ld_fwd && ld_data == mem_rd_data));

  assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (full_q && op_class >= 3'd3) |-> !issue_ok);

  assert_free_R6: assert property (@(posedge clk) disable iff (rst)
    (op_class < 3'd3) |-> issue_ok);

  assert_flush_drains_R7: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !st_req && full_q) |=> (mem_wr_en && !full_q));

  assert_empty_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !full_q) |=> !mem_wr_en);

  assert_full_store_R9: assert property (@(posedge clk) disable iff (rst)
    (st_req && !fl_req && full_q) |=> ($stable(ent_addr) && $stable(ent_data) && full_q));

  assert_both_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (st_req && fl_req) |=> ($stable(full_q) && $stable(ent_addr) && !mem_wr_en));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);
endmodule

bind sbe_top sbe_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_class    (op_class),
  .issue_ok    (issue_ok),
  .st_req      (st_req),
  .fl_req      (fl_req),
  .ld_addr     (ld_addr),
  .mem_rd_data (mem_rd_data),
  .ld_data     (ld_data),
  .ld_fwd      (ld_fwd),
  .mem_wr_en   (mem_wr_en),
  .proto_err   (proto_err),
  .full_q      (full_q),
  .ent_addr    (ent_addr),
  .ent_data    (ent_data)
);

// File: tb/sbe_top_test.sv
module sbe_top_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_class = '0;
  logic          issue_ok;
  logic          st_req = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] acc_in = '0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] ld_data;
  logic          ld_fwd;
  logic          fl_req = 1'b0;
  logic          flush_ok;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          proto_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural reference state.
  bit m_full = 0;
  int m_addr = 0;
  int m_data = 0;
  bit m_pulse = 0;
  int m_paddr = 0;
  int m_pdata = 0;

  always #(PERIOD/2) clk = ~clk;

  sbe_top #(.AW(AW), .DW(DW)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare, then advance the model at the edge.
  task automatic step(input bit st, input bit fl, input int op, input int la,
                      input int md, input int sa, input int ac);
    bit e_hit; int e_ld; bit e_ok; bit e_err;
    bit n_full; int n_addr; int n_data; bit n_pulse;
    @(negedge clk);
    st_req = st; fl_req = fl; op_class = 3'(op); ld_addr = AW'(la);
    mem_rd_data = DW'(md); st_addr = AW'(sa); acc_in = DW'(ac);
    #1;
    e_hit = m_full && (la == m_addr);
    e_ld  = e_hit ? m_data : md;
    e_ok  = (op <= 2) ? 1'b1 : !m_full;
    e_err = st && fl;
    chk(ld_fwd == e_hit, e_hit ? "R3 fwd" : "R4 fwd", int'(ld_fwd), int'(e_hit));
    chk(int'(ld_data) == e_ld, e_hit ? "R3 data" : "R4 data", int'(ld_data), e_ld);
    chk(issue_ok == e_ok, (op <= 2) ? "R6 issue" : "R5 issue", int'(issue_ok), int'(e_ok));
    chk(proto_err == e_err, "R10 err", int'(proto_err), int'(e_err));
    chk(flush_ok == m_full, "R2/R9 full", int'(flush_ok), int'(m_full));
    chk(mem_wr_en == m_pulse, "R7/R11 strobe", int'(mem_wr_en), int'(m_pulse));
    if (m_pulse) begin
      chk(int'(mem_wr_addr) == m_paddr, "R7 waddr", int'(mem_wr_addr), m_paddr);
      chk(int'(mem_wr_data) == m_pdata, "R7 wdata", int'(mem_wr_data), m_pdata);
    end
    n_full = m_full; n_addr = m_addr; n_data = m_data; n_pulse = 0;
    if (!e_err) begin
      if (fl && m_full) begin
        n_full = 0; n_pulse = 1;
      end else if (st && !m_full) begin
        n_full = 1; n_addr = sa; n_data = ac;
      end
    end
    @(posedge clk);
    if (n_pulse) begin m_paddr = m_addr; m_pdata = m_data; end
    m_full = n_full; m_addr = n_addr; m_data = n_data; m_pulse = n_pulse;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(flush_ok == 1'b0, "R1 full in reset", int'(flush_ok), 0);
    chk(mem_wr_en == 1'b0, "R1 strobe in reset", int'(mem_wr_en), 0);
    rst = 1'b0;
    @(posedge clk);
    // R1: first cycle after reset, stimulus idle; empty-buffer flush ignored (R8).
    step(0, 1, 5, 1, 100, 0, 0);
    step(0, 0, 3, 1, 101, 0, 0);
    // R2 store, then R3 hit, R4 miss, R5 stall, R6 free.
    step(1, 0, 3, 9, 200, 9, 16'h1234);
    step(0, 0, 5, 9, 201, 0, 0);
    step(0, 0, 0, 8, 202, 0, 0);
    step(0, 0, 6, 8, 203, 0, 0);
    step(0, 0, 2, 9, 204, 0, 0);
    // R9: store while full ignored, check via forwarding.
    step(1, 0, 3, 7, 205, 7, 16'hBEEF);
    step(0, 0, 1, 9, 206, 0, 0);
    step(0, 0, 0, 7, 207, 0, 0);
    // R10: both together ignored.
    step(1, 1, 4, 9, 208, 3, 16'h5555);
    step(0, 0, 4, 9, 209, 0, 0);
    // R7 flush, then store right in the strobe cycle, then flush again (R11).
    step(0, 1, 0, 9, 210, 0, 0);
    step(1, 0, 3, 9, 211, 4, 16'h0AAA);
    step(0, 1, 0, 4, 212, 0, 0);
    step(0, 0, 0, 4, 213, 0, 0);
    step(0, 1, 7, 4, 214, 0, 0);
    step(0, 0, 7, 4, 215, 0, 0);
    // Pseudo-random phase over a small address set.
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, ($urandom % 3) == 0, int'($urandom % 8),
           int'($urandom % 4), int'($urandom % 65536), int'($urandom % 4),
           int'($urandom % 65536));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule